// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Timer

The block is a pulse-width modulation timer built around one shared up-counter and a set of compare channels (four by default). Each channel drives one output that rises when the counter reloads and falls when the counter reaches that channel's compare value. This gives edge-aligned, high-true pulses whose period is set by a modulo register and whose width is set per channel. Software drives the block through a simple word-wide register port. Writes take effect on a clock edge, and reads are combinational.

The register map is word-addressed. Address 0 is the control word, 1 is the modulo (period), 2 is the global word holding a software reset, and 3 is a read-only view of the counter. For channel i, address 4+2i holds its mode word and 5+2i its compare value. A combinational helper converts a 16.16 fixed-point duty fraction into the compare value that matches the period currently programmed. Software can write that value to a channel.

Top module: `epwm_timer`

## Requirements
- R1: After the asynchronous reset, every register reads 0, the counter reads 0 and all outputs are low. Address map: 0 control, 1 modulo, 2 global, 3 counter (read-only), 4+2i channel mode, 5+2i channel compare.
- R2: The clock-mode field is control bits [1:0]. Value 1 advances the counter. Values 0, 2 and 3 stop it, and it then keeps its value.
- R3: The prescaler field is control bits [4:2], holding p. The counter advances once every 2^p clocks, so p = 0 advances it on every clock.
- R4: With modulo M, the counter counts 0..M and then wraps to 0 on the next advance (the reload). The output period is therefore (M+1)·2^p clocks.
- R5: A channel runs high-true edge-aligned only when control bit 5 (center select) is 0 and the channel mode word [3:0] is 4'b1000. In that word, bits [3:2] are the mode pair 2'b10 and bits [1:0] are the level pair 2'b00. Any other word, including 0, holds the channel output low.
- R6: An active channel with compare C sets its output at reload and clears it when the counter reaches C. It is high for min(C, M+1)·2^p clocks per period, so C = 0 gives constant low and C > M gives constant high.
- R7: Outputs are low while the counter is stopped. After the counter is first enabled or resumed, they stay low until the first reload.
- R8: Modulo and compare values written while the counter runs take effect at the next reload. Values written while it is stopped take effect at once.
- R9: Global bit 0 is a software reset. While it is 1, it reads back 1, and every other register, the counter and the outputs are held at their reset values, with writes to them ignored. Writing 0 releases the block and the global word reads 0.
- R10: duty_cmp equals (duty_frac × modulo + 0x8000) >> 16, where duty_frac is an unsigned 16.16 fraction and the modulo is the programmed register. The output is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| duty_frac | input | 32 | 16.16 duty fraction for the helper |
| duty_cmp | output | 32 | Rounded compare value for duty_frac |
| pwm_out | output | NCH (4) | Channel outputs |

## Verification
A register write lands on the edge where the strobe is sampled. The counter first advances one edge after the enable write, or 2^p edges later with a prescaler. Each output changes on the same edge as the reload or compare event that causes it. A pause clears the outputs one edge after the control write, and a software reset clears the other registers one edge after the global bit is set. The bench therefore drives on falling edges, samples on later falling edges, and counts those edges exactly from each write. Duty is measured over one whole period after two periods have settled, which removes any dependence on phase. The helper result is sampled shortly after its inputs change.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  // word addresses of the register port
  localparam int CTRL_ADDR = 0;
  localparam int MOD_ADDR  = 1;
  localparam int GLB_ADDR  = 2;
  localparam int CNT_ADDR  = 3;
  localparam int CH_BASE   = 4;

  localparam int PS_W   = 3;
  localparam int PRE_W  = (1 << PS_W) - 1;
  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    CLK_OFF   = 2'd0,
    CLK_EVERY = 2'd1,
    CLK_RSV2  = 2'd2,
    CLK_RSV3  = 2'd3
  } clk_mode_e;

  typedef struct packed {
    logic            center;  // bit 5
    logic [PS_W-1:0] presc;   // bits 4:2
    clk_mode_e       cmode;   // bits 1:0
  } ctrl_t;

  // mode pair 2'b10, level pair 2'b00
  localparam logic [3:0] CH_EDGE_HI = 4'b1000;

  function automatic logic edge_hi_sel(input logic [3:0] ctl, input logic center);
    return (!center) && (ctl == CH_EDGE_HI);
  endfunction

  // round-to-nearest scaling of a 16.16 fraction by the period
  function automatic logic [31:0] duty_to_cmp(input logic [31:0] duty,
                                              input logic [31:0] period);
    logic [63:0] prod;
    prod = ({32'd0, duty} * {32'd0, period}) + 64'h8000;
    return 32'(prod >> 16);
  endfunction

endpackage

// File: rtl/epwm_regfile.sv
module epwm_regfile
  import epwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [CNT_W-1:0]           count,
  output logic [DATA_W-1:0]          rdata,
  output ctrl_t                      ctrl,
  output logic [CNT_W-1:0]           mod_val,
  output logic                       soft_rst,
  output logic [NCH-1:0][3:0]        ch_ctl,
  output logic [NCH-1:0][CNT_W-1:0]  ch_cmp
);

  ctrl_t                      ctrl_q;
  logic [CNT_W-1:0]           mod_q;
  logic                       glb_q;
  logic [NCH-1:0][3:0]        ctl_q;
  logic [NCH-1:0][CNT_W-1:0]  cmp_q;

  logic unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mod_q  <= '0;
      glb_q  <= 1'b0;
      ctl_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr && addr == ADDR_W'(GLB_ADDR)) glb_q <= wdata[0];
      if (glb_q) begin
        ctrl_q <= '0;
        mod_q  <= '0;
        ctl_q  <= '0;
        cmp_q  <= '0;
      end else if (wr) begin
        if (addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        if (addr == ADDR_W'(MOD_ADDR))  mod_q  <= wdata[CNT_W-1:0];
        for (int i = 0; i < NCH; i++) begin
          if (addr == ADDR_W'(CH_BASE + 2*i))     ctl_q[i] <= wdata[3:0];
          if (addr == ADDR_W'(CH_BASE + 2*i + 1)) cmp_q[i] <= wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) rdata = DATA_W'(ctrl_q);
    if (addr == ADDR_W'(MOD_ADDR))  rdata = DATA_W'(mod_q);
    if (addr == ADDR_W'(GLB_ADDR))  rdata = DATA_W'(glb_q);
    if (addr == ADDR_W'(CNT_ADDR))  rdata = DATA_W'(count);
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(CH_BASE + 2*i))     rdata = DATA_W'(ctl_q[i]);
      if (addr == ADDR_W'(CH_BASE + 2*i + 1)) rdata = DATA_W'(cmp_q[i]);
    end
  end

  assign ctrl     = ctrl_q;
  assign mod_val  = mod_q;
  assign soft_rst = glb_q;
  assign ch_ctl   = ctl_q;
  assign ch_cmp   = cmp_q;

endmodule

// File: rtl/epwm_counter.sv
module epwm_counter
  import epwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclr,
  input  logic              run,
  input  logic [PS_W-1:0]   presc,
  input  logic [CNT_W-1:0]  mod_val,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  mod_act,
  output logic              tick,
  output logic              reload
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_lim;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_q;

  assign pre_lim = ~({PRE_W{1'b1}} << presc);
  assign tick    = run && (pre_q >= pre_lim);
  assign reload  = tick && (cnt_q >= mod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      mod_q <= '0;
    end else if (sclr) begin
      pre_q <= '0;
      cnt_q <= '0;
      mod_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      mod_q <= mod_val;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (reload) begin
        cnt_q <= '0;
        mod_q <= mod_val;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count   = cnt_q;
  assign mod_act = mod_q;

endmodule

// File: rtl/epwm_channel.sv
module epwm_channel
  import epwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclr,
  input  logic              run,
  input  logic              tick,
  input  logic              reload,
  input  logic [CNT_W-1:0]  count,
  input  logic [3:0]        ctl,
  input  logic              center,
  input  logic [CNT_W-1:0]  cmp_val,
  output logic              sel,
  output logic [CNT_W-1:0]  cmp_act,
  output logic              out
);

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] nxt_cnt;
  logic             out_q;

  assign sel     = edge_hi_sel(ctl, center);
  assign nxt_cnt = count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      out_q <= 1'b0;
    end else if (sclr) begin
      cmp_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (!run || reload) cmp_q <= cmp_val;
      if (!run || !sel)                    out_q <= 1'b0;
      else if (reload)                     out_q <= (cmp_val != '0);
      else if (tick && nxt_cnt == cmp_q)   out_q <= 1'b0;
    end
  end

  assign cmp_act = cmp_q;
  assign out     = out_q;

endmodule

// File: rtl/epwm_duty.sv
module epwm_duty
  import epwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [31:0]      duty,
  input  logic [CNT_W-1:0] period,
  output logic [31:0]      cmp
);

  assign cmp = duty_to_cmp(duty, 32'(period));

endmodule

// File: rtl/epwm_timer.sv
module epwm_timer
  import epwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(CH_BASE + 2*NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [31:0]       duty_frac,
  output logic [31:0]       duty_cmp,
  output logic [NCH-1:0]    pwm_out
);

  ctrl_t                      ctrl;
  logic [CNT_W-1:0]           mod_val;
  logic                       soft_rst;
  logic [NCH-1:0][3:0]        ch_ctl;
  logic [NCH-1:0][CNT_W-1:0]  ch_cmp;

  // named internal events
  logic                       cnt_run;
  logic                       cnt_tick;
  logic                       cnt_reload;
  logic [CNT_W-1:0]           count_q;
  logic [CNT_W-1:0]           mod_act;
  logic [NCH-1:0]             ch_sel;
  logic [NCH-1:0][CNT_W-1:0]  ch_cmp_act;

  assign cnt_run = (ctrl.cmode == CLK_EVERY);

  epwm_regfile #(
    .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count_q), .rdata(bus_rdata), .ctrl(ctrl), .mod_val(mod_val),
    .soft_rst(soft_rst), .ch_ctl(ch_ctl), .ch_cmp(ch_cmp)
  );

  epwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sclr(soft_rst), .run(cnt_run),
    .presc(ctrl.presc), .mod_val(mod_val), .count(count_q),
    .mod_act(mod_act), .tick(cnt_tick), .reload(cnt_reload)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    epwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .sclr(soft_rst), .run(cnt_run),
      .tick(cnt_tick), .reload(cnt_reload), .count(count_q),
      .ctl(ch_ctl[g]), .center(ctrl.center), .cmp_val(ch_cmp[g]),
      .sel(ch_sel[g]), .cmp_act(ch_cmp_act[g]), .out(pwm_out[g])
    );
  end

  epwm_duty #(.CNT_W(CNT_W)) u_duty (
    .duty(duty_frac), .period(mod_val), .cmp(duty_cmp)
  );

endmodule

// File: rtl/epwm_checker.sv
module epwm_checker #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      soft_rst,
  input logic                      cnt_run,
  input logic                      cnt_tick,
  input logic                      cnt_reload,
  input logic [CNT_W-1:0]          count_q,
  input logic [CNT_W-1:0]          mod_act,
  input logic [NCH-1:0]            ch_sel,
  input logic [NCH-1:0][CNT_W-1:0] ch_cmp_act,
  input logic [NCH-1:0]            pwm_out
);

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_run |=> (pwm_out == '0));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_reload && !soft_rst) |=> (count_q == '0));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_reload && !soft_rst) |=> (count_q == $past(count_q) + 1'b1));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !soft_rst) |=> $stable(count_q));

  assert_within_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !soft_rst) |=> (count_q <= mod_act));

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count_q == '0 && pwm_out == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_reload_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_reload && ch_sel[g] && !soft_rst) |=> (pwm_out[g] == (ch_cmp_act[g] != '0)));
    assert_unselected_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_sel[g] |=> !pwm_out[g]);
  end

endmodule

bind epwm_timer epwm_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cnt_run(cnt_run),
  .cnt_tick(cnt_tick), .cnt_reload(cnt_reload), .count_q(count_q),
  .mod_act(mod_act), .ch_sel(ch_sel), .ch_cmp_act(ch_cmp_act),
  .pwm_out(pwm_out)
);

// File: tb/epwm_timer_test.sv
module epwm_timer_test;

  localparam int NCH = 4;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [31:0]   duty_frac = '0;
  logic [31:0]   duty_cmp;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int hi_cnt [NCH];
  int cval [NCH];
  bit done = 1'b0;

  always #10 clk = ~clk;

  epwm_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .duty_frac(duty_frac),
    .duty_cmp(duty_cmp), .pwm_out(pwm_out)
  );

  function automatic longint exp_high(input int c, input int m, input int ps);
    int w;
    w = (c < m + 1) ? c : m + 1;
    return longint'(w) << ps;
  endfunction

  function automatic longint exp_duty(input logic [31:0] d, input int p);
    longint unsigned t;
    t = longint'(d) * longint'(p) + 64'd32768;
    return longint'(t / 65536);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = 32'(d);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = AW'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic soft_reset();
    wr(2, 1);
    wr(2, 0);
  endtask

  task automatic measure(input int win);
    for (int ch = 0; ch < NCH; ch++) hi_cnt[ch] = 0;
    repeat (win) begin
      @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) if (pwm_out[ch]) hi_cnt[ch]++;
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_out[ch];
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, v2, mx, m, ps, p;
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(a, v);
      check("R1", $sformatf("reg %0d after reset", a), v, 0);
    end
    check("R1", "outputs after reset", pwm_out, 0);

    // R2 counter runs on mode 1, every clock
    wr(1, 100); wr(0, 1);
    repeat (7) @(negedge clk);
    rd(3, v); check("R2", "count after 7 clocks", v, 7);
    soft_reset();
    wr(1, 100); wr(0, 2);
    repeat (6) @(negedge clk);
    rd(3, v); check("R2", "count held in mode 2", v, 0);

    // R3 prescaler p=2
    soft_reset();
    wr(1, 100); wr(0, (2 << 2) | 1);
    repeat (40) @(negedge clk);
    rd(3, v); check("R3", "count after 40 clocks at p=2", v, 10);

    // R7 first enable keeps output low until first reload
    soft_reset();
    wr(1, 6); wr(4, 8); wr(5, 3); wr(0, 1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R7", $sformatf("low before first reload k=%0d", k), pwm_out[0], 0);
    end
    @(negedge clk);
    check("R7", "high after first reload", pwm_out[0], 1);

    // R7 pause and resume
    soft_reset();
    wr(1, 9); wr(4, 8); wr(5, 5); wr(0, 1);
    repeat (30) @(negedge clk);
    wr(0, 0);
    @(negedge clk);
    check("R7", "low when paused", pwm_out, 0);
    rd(3, v);
    repeat (5) @(negedge clk);
    rd(3, v2); check("R2", "count held when paused", v2, v);
    wr(0, 1);
    for (int k = 1; k <= 9 - v; k++) begin
      @(negedge clk);
      check("R7", "low after resume before reload", pwm_out[0], 0);
    end
    @(negedge clk);
    check("R7", "high at reload after resume", pwm_out[0], 1);

    // R5 mode word decode and center select
    soft_reset();
    wr(1, 7);
    wr(4, 8); wr(6, 9); wr(8, 4); wr(10, 0);
    for (int ch = 0; ch < NCH; ch++) wr(5 + 2*ch, 4);
    wr(0, 1);
    repeat (40) @(negedge clk);
    measure(8);
    check("R5", "valid word ch0", hi_cnt[0], 4);
    check("R5", "level bit set ch1", hi_cnt[1], 0);
    check("R5", "wrong mode pair ch2", hi_cnt[2], 0);
    check("R5", "zero word ch3", hi_cnt[3], 0);
    wr(0, 32'h21);
    repeat (20) @(negedge clk);
    measure(8);
    check("R5", "center select forces low", hi_cnt[0], 0);
    wr(0, 1);
    repeat (20) @(negedge clk);
    wr(4, 0);
    repeat (2) @(negedge clk);
    measure(16);
    check("R5", "write 0 disables ch0", hi_cnt[0], 0);

    // R8 compare buffered until reload
    soft_reset();
    wr(1, 20); wr(4, 8); wr(5, 15); wr(0, 1);
    repeat (50) @(negedge clk);
    wait_rise(0);
    wr(5, 5);
    repeat (10) @(negedge clk);
    check("R8", "old compare kept in current period", pwm_out[0], 1);
    repeat (50) @(negedge clk);
    measure(21);
    check("R8", "new compare after reload", hi_cnt[0], 5);

    // R8 modulo buffered until reload
    soft_reset();
    wr(1, 50); wr(4, 8); wr(5, 10); wr(0, 1);
    repeat (60) @(negedge clk);
    wait_rise(0);
    wr(1, 10);
    repeat (20) @(negedge clk);
    rd(3, v); check("R8", "old modulo kept in current period", v, 21);
    repeat (60) @(negedge clk);
    mx = 0;
    repeat (30) begin
      @(negedge clk);
      rd(3, v);
      if (v > mx) mx = v;
    end
    check("R4", "new modulo is the wrap point", mx, 10);

    // R9 software reset
    wr(0, 1); wr(5, 3);
    wr(2, 1);
    @(negedge clk);
    rd(2, v); check("R9", "global reads 1", v, 1);
    rd(1, v); check("R9", "modulo cleared", v, 0);
    rd(3, v); check("R9", "counter cleared", v, 0);
    check("R9", "outputs cleared", pwm_out, 0);
    wr(1, 77);
    wr(2, 0);
    rd(2, v); check("R9", "global reads 0", v, 0);
    rd(1, v); check("R9", "write ignored during reset", v, 0);

    // R4 R6 random configurations
    for (int t = 0; t < 30; t++) begin
      m  = int'($urandom_range(0, 40));
      ps = int'($urandom_range(0, 3));
      if (t == 0) m = 0;
      soft_reset();
      wr(1, m);
      for (int ch = 0; ch < NCH; ch++) begin
        cval[ch] = int'($urandom_range(0, m + 3));
        if (t == 1) cval[ch] = (ch == 0) ? 0 : m + 1 + ch;
        wr(4 + 2*ch, 8);
        wr(5 + 2*ch, cval[ch]);
      end
      wr(0, (ps << 2) | 1);
      p = (m + 1) << ps;
      repeat (2*p + 4) @(negedge clk);
      measure(p);
      for (int ch = 0; ch < NCH; ch++)
        check("R6", $sformatf("high time t=%0d ch=%0d M=%0d C=%0d p=%0d", t, ch, m, cval[ch], ps),
              hi_cnt[ch], exp_high(cval[ch], m, ps));
      rd(3, v);
      check("R4", "count within modulo", (v <= m) ? 1 : 0, 1);
    end

    // R10 duty helper
    soft_reset();
    for (int t = 0; t < 24; t++) begin
      m = int'($urandom_range(0, 65535));
      d = $urandom_range(0, 32'h0001_0000);
      if (t == 0) begin m = 1001; d = 32'h8000; end
      if (t == 1) begin m = 500;  d = 32'h0001_0000; end
      if (t == 2) begin m = 65535; d = 32'hFFFF_FFFF; end
      if (t == 3) begin m = 3; d = 0; end
      wr(1, m);
      duty_frac = d;
      #1;
      check("R10", $sformatf("duty %0h period %0d", d, m), longint'(duty_cmp), exp_duty(d, m));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule